// File: doc/BRIEF.md
# Byte-Programmed PWM Generator with Auto-Off Timer

This block produces one active-high pulse-width-modulated output from two 16-bit counts: a period and a high time. Both counts, plus an auto-off timeout, are written over a simple synchronous byte-write port made of an address, a data byte and a one-cycle write strobe. There is no read path. Each 16-bit count is split into two byte registers. Writing the upper byte only parks it in a holding register. Writing the lower byte combines it with the parked upper byte and makes the full value live on the next clock. Period and high time therefore update one after the other, never together.

The counts are in ticks of a time base that is derived from the clock through a parameterised divider. An enable register starts or stops the waveform. An auto-off timer, counted in milliseconds of `TICKS_PER_MS` ticks, clears the enable when it runs out. A timeout value of all ones keeps the timer permanently idle. A typical use is a backlight or buzzer driver that is programmed once and then left alone. The watchdog-like timeout turns it off if the host stops servicing it.

Top module: `pwmao_top`

## Requirements
- R1: After reset the output is low, the live period, high time and enable are all zero, and the auto-off timeout is 0xFFFF (timer idle).
- R2: The byte registers decode at these addresses: 0xA1 timeout upper, 0xA2 timeout lower, 0xA3 enable, 0xA4 period lower, 0xA5 period upper, 0xA6 high-time lower, 0xA7 high-time upper.
- R3: A write to an upper-byte address changes no live value and leaves the output waveform unchanged.
- R4: A write to a lower-byte address loads {parked upper byte, written byte} into the live value, and it takes effect on the next clock without waiting for a period boundary.
- R5: With enable set and period P > 0, the phase counter steps 0..P-1 once per tick and wraps. Every P ticks the output is high for min(D, P) ticks, where D is the high time.
- R6: When D >= P and P > 0, the output stays high continuously while enabled.
- R7: A period of 0 or a high time of 0 keeps the output low.
- R8: Only bit 0 of the enable byte is used. A 0 there forces the output low, and a 1 starts generation.
- R9: While the timer is active and enabled, the timeout decrements once per TICKS_PER_MS ticks. On reaching zero it clears enable, so the output goes low. A later enable write is refused while the timeout sits at zero.
- R10: A timeout of 0xFFFF idles the timer, and generation then continues indefinitely.
- R11: Writing the timeout lower byte reloads the remaining time and restarts the millisecond prescaler, even in the middle of a countdown.
- R12: Writes to any address outside 0xA1..0xA7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_i | input | 1 | Single-cycle byte write strobe |
| addr_i | input | 8 | Register address |
| data_i | input | 8 | Write data byte |
| pwm_o | output | 1 | Registered PWM output, active high |

## Verification
The assertions assume that there is at most one write per cycle, that the address and data are defined whenever the strobe is high, and that reset is applied before the first write. The timing properties also assume that the timeout is reloaded only by its lower-byte address. The stimulus drives every write as a single isolated strobe cycle followed by an idle cycle, on the inactive clock edge. Waveform checks count high cycles over windows that are whole multiples of the period. Because of that the expected duty comes out arithmetically, whatever the phase at which the window opens.

// File: rtl/pwmao_pkg.sv
package pwmao_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned VAL_W  = 2 * BYTE_W;
  localparam int unsigned ADDR_W = 8;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [VAL_W-1:0]  val_t;

  localparam addr_t A_TMO_HI  = 8'hA1;
  localparam addr_t A_TMO_LO  = 8'hA2;
  localparam addr_t A_ENABLE  = 8'hA3;
  localparam addr_t A_PER_LO  = 8'hA4;
  localparam addr_t A_PER_HI  = 8'hA5;
  localparam addr_t A_HIGH_LO = 8'hA6;
  localparam addr_t A_HIGH_HI = 8'hA7;

  localparam int unsigned N_PAIRS   = 3;
  localparam int unsigned PAIR_PER  = 0;
  localparam int unsigned PAIR_HIGH = 1;
  localparam int unsigned PAIR_TMO  = 2;

  function automatic addr_t pair_hi_addr(int unsigned idx);
    case (idx)
      PAIR_PER:  return A_PER_HI;
      PAIR_HIGH: return A_HIGH_HI;
      default:   return A_TMO_HI;
    endcase
  endfunction

  function automatic addr_t pair_lo_addr(int unsigned idx);
    case (idx)
      PAIR_PER:  return A_PER_LO;
      PAIR_HIGH: return A_HIGH_LO;
      default:   return A_TMO_LO;
    endcase
  endfunction

  function automatic val_t pair_rst_val(int unsigned idx);
    return (idx == PAIR_TMO) ? '1 : '0;
  endfunction

endpackage

// File: rtl/pwmao_pair.sv
module pwmao_pair
  import pwmao_pkg::*;
#(
  parameter addr_t HI_ADDR = 8'h00,
  parameter addr_t LO_ADDR = 8'h01,
  parameter val_t  RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  addr_t             addr_i,
  input  logic [BYTE_W-1:0] data_i,
  output val_t              value_o
);

  logic [BYTE_W-1:0] park_q, park_d;
  val_t              live_q, live_d;
  logic              park_en, live_en;

  always_comb begin
    park_en = wr_i && (addr_i == HI_ADDR);
    live_en = wr_i && (addr_i == LO_ADDR);
    park_d  = data_i;
    live_d  = {park_q, data_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      park_q <= RST_VAL[VAL_W-1:BYTE_W];
      live_q <= RST_VAL;
    end else begin
      if (park_en) park_q <= park_d;
      if (live_en) live_q <= live_d;
    end
  end

  assign value_o = live_q;

endmodule

// File: rtl/pwmao_tick.sv
module pwmao_tick #(
  parameter int unsigned CLK_PER_TICK = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  localparam int unsigned PRE_W = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(CLK_PER_TICK - 1);

  logic [PRE_W-1:0] pre_q, pre_d;

  always_comb begin
    tick_o = (pre_q == LAST);
    pre_d  = tick_o ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

endmodule

// File: rtl/pwmao_ctrl.sv
module pwmao_ctrl
  import pwmao_pkg::*;
#(
  parameter int unsigned TICKS_PER_MS = 8000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic en_wr_i,
  input  logic en_bit_i,
  input  logic load_i,
  input  val_t load_val_i,
  output logic en_o
);

  localparam int unsigned MS_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam logic [MS_W-1:0] MS_LAST = MS_W'(TICKS_PER_MS - 1);

  logic            en_q, en_d;
  val_t            left_q, left_d;
  logic [MS_W-1:0] ms_q, ms_d;
  logic            armed, at_zero, expire, step;

  always_comb begin
    armed   = (left_q != '1);
    at_zero = (left_q == '0);
    expire  = en_q && armed && at_zero;
    step    = en_q && armed && !at_zero && tick_i;

    if (en_wr_i)     en_d = en_bit_i && !(armed && at_zero);
    else if (expire) en_d = 1'b0;
    else             en_d = en_q;

    left_d = left_q;
    ms_d   = ms_q;
    if (load_i) begin
      left_d = load_val_i;
      ms_d   = '0;
    end else if (!en_q) begin
      ms_d   = '0;
    end else if (step) begin
      if (ms_q == MS_LAST) begin
        ms_d   = '0;
        left_d = left_q - 1'b1;
      end else begin
        ms_d   = ms_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      left_q <= '1;
      ms_q   <= '0;
    end else begin
      en_q   <= en_d;
      left_q <= left_d;
      ms_q   <= ms_d;
    end
  end

  assign en_o = en_q;

endmodule

// File: rtl/pwmao_wave.sv
module pwmao_wave
  import pwmao_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic en_i,
  input  val_t period_i,
  input  val_t high_i,
  output logic pwm_o
);

  val_t cnt_q, cnt_d;
  logic out_q, out_d;
  logic at_end;

  always_comb begin
    at_end = (cnt_q == period_i - 1'b1);
    if (!en_i)                  cnt_d = '0;
    else if (cnt_q >= period_i) cnt_d = '0;
    else if (tick_i)            cnt_d = at_end ? '0 : cnt_q + 1'b1;
    else                        cnt_d = cnt_q;

    out_d = en_i && (period_i != '0) && (cnt_q < period_i) && (cnt_q < high_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign pwm_o = out_q;

endmodule

// File: rtl/pwmao_top.sv
module pwmao_top
  import pwmao_pkg::*;
#(
  parameter int unsigned CLK_PER_TICK = 1,
  parameter int unsigned TICKS_PER_MS = 8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              pwm_o
);

  logic [1:0] rst_pipe;
  logic       rst_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_l = rst_pipe[1];

  val_t pair_val [N_PAIRS];

  for (genvar g = 0; g < N_PAIRS; g++) begin : g_pair
    pwmao_pair #(
      .HI_ADDR (pair_hi_addr(g)),
      .LO_ADDR (pair_lo_addr(g)),
      .RST_VAL (pair_rst_val(g))
    ) u_pair (
      .clk     (clk),
      .rst_n   (rst_l),
      .wr_i    (wr_i),
      .addr_i  (addr_i),
      .data_i  (data_i),
      .value_o (pair_val[g])
    );
  end

  val_t period, high;
  logic en_wr, en, tick;
  logic tmo_load_q, tmo_load_d;

  always_comb begin
    period     = pair_val[PAIR_PER];
    high       = pair_val[PAIR_HIGH];
    en_wr      = wr_i && (addr_i == A_ENABLE);
    tmo_load_d = wr_i && (addr_i == A_TMO_LO);
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) tmo_load_q <= 1'b0;
    else        tmo_load_q <= tmo_load_d;
  end

  pwmao_tick #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
    .clk    (clk),
    .rst_n  (rst_l),
    .tick_o (tick)
  );

  pwmao_ctrl #(.TICKS_PER_MS(TICKS_PER_MS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_l),
    .tick_i     (tick),
    .en_wr_i    (en_wr),
    .en_bit_i   (data_i[0]),
    .load_i     (tmo_load_q),
    .load_val_i (pair_val[PAIR_TMO]),
    .en_o       (en)
  );

  pwmao_wave u_wave (
    .clk      (clk),
    .rst_n    (rst_l),
    .tick_i   (tick),
    .en_i     (en),
    .period_i (period),
    .high_i   (high),
    .pwm_o    (pwm_o)
  );

endmodule

// File: rtl/pwmao_chk.sv
module pwmao_chk
  import pwmao_pkg::*;
(
  input logic  clk,
  input logic  rst_l,
  input logic  wr,
  input addr_t addr,
  input logic  pwm,
  input logic  en,
  input val_t  period,
  input val_t  high,
  input val_t  cnt,
  input val_t  left,
  input logic  load
);

  logic mapped;
  assign mapped = (addr >= A_TMO_HI) && (addr <= A_HIGH_HI);

  p_off_when_disabled_r8: assert property (@(posedge clk) disable iff (!rst_l)
    !en |=> !pwm);

  p_zero_period_low_r7: assert property (@(posedge clk) disable iff (!rst_l)
    (period == '0) |=> !pwm);

  p_full_high_r6: assert property (@(posedge clk) disable iff (!rst_l)
    (en && period != '0 && high >= period && cnt < period) |=> pwm);

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_l)
    (en && $past(en) && $stable(period) && period != '0) |-> (cnt < period));

  p_upper_parks_r3: assert property (@(posedge clk) disable iff (!rst_l)
    (wr && (addr == A_PER_HI || addr == A_HIGH_HI)) |=> ($stable(period) && $stable(high)));

  p_expire_clears_r9: assert property (@(posedge clk) disable iff (!rst_l)
    (en && left == '0 && !(wr && addr == A_ENABLE)) |=> !en);

  p_idle_timer_holds_r10: assert property (@(posedge clk) disable iff (!rst_l)
    (left == '1 && !load) |=> (left == '1));

  p_unmapped_ignored_r12: assert property (@(posedge clk) disable iff (!rst_l)
    (wr && !mapped) |=> ($stable(period) && $stable(high) && $stable(left)));

endmodule

bind pwmao_top pwmao_chk u_chk (
  .clk    (clk),
  .rst_l  (rst_l),
  .wr     (wr_i),
  .addr   (addr_i),
  .pwm    (pwm_o),
  .en     (en),
  .period (period),
  .high   (high),
  .cnt    (u_wave.cnt_q),
  .left   (u_ctrl.left_q),
  .load   (tmo_load_q)
);

// File: tb/tb_pwmao_top.sv
module tb_pwmao_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] addr_i = 8'h00;
  logic [7:0] data_i = 8'h00;
  logic       pwm_o;

  int checks = 0;
  int fails  = 0;
  int hi_total = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwmao_top #(.CLK_PER_TICK(1), .TICKS_PER_MS(4)) dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (wr_i),
    .addr_i (addr_i),
    .data_i (data_i),
    .pwm_o  (pwm_o)
  );

  always @(negedge clk) if (pwm_o === 1'b1) hi_total++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_i = 1'b1; addr_i = a; data_i = d;
    @(negedge clk);
    wr_i = 1'b0; addr_i = 8'h00; data_i = 8'h00;
  endtask

  task automatic highs(input int n, output int h);
    int start;
    start = hi_total;
    repeat (n) @(negedge clk);
    h = hi_total - start;
  endtask

  task automatic set_wave(input int p, input int d);
    wr(8'hA5, 8'(p >> 8)); wr(8'hA4, 8'(p));   // R2 period upper/lower
    wr(8'hA7, 8'(d >> 8)); wr(8'hA6, 8'(d));   // R2 high-time upper/lower
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    int h;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(pwm_o === 1'b0, "R1 output low after reset", int'(pwm_o), 0);
    highs(8, h);
    check(h == 0, "R1 idle after reset", h, 0);
    wr(8'hA3, 8'h01);
    highs(16, h);
    check(h == 0, "R1/R7 zero period from reset keeps low", h, 0);

    // R5 R6 R7 sweep of period and high time
    for (int p = 0; p < 8; p++) begin
      for (int d = 0; d < 10; d++) begin
        int win, exp;
        set_wave(p, d);
        wr(8'hA3, 8'h01);
        repeat (4) @(negedge clk);
        win = (p == 0) ? 16 : 4 * p;
        exp = (p == 0) ? 0 : 4 * ((d < p) ? d : p);
        highs(win, h);
        if (p == 0 || d == 0)  check(h == exp, "R7 zero period or high time", h, exp);
        else if (d >= p)       check(h == exp, "R6 continuous high", h, exp);
        else                   check(h == exp, "R5 high ticks per period", h, exp);
      end
    end

    // R3 R4 staging and commit
    set_wave(4, 2);
    repeat (4) @(negedge clk);
    wr(8'hA5, 8'h01);
    highs(16, h);
    check(h == 8, "R3 period upper byte parks only", h, 8);
    wr(8'hA4, 8'h04);
    repeat (4) @(negedge clk);
    highs(520, h);
    check(h == 4, "R4 period commit 0x0104", h, 4);
    wr(8'hA5, 8'h00); wr(8'hA4, 8'h04);
    repeat (4) @(negedge clk);
    wr(8'hA7, 8'h01);
    highs(16, h);
    check(h == 8, "R3 high-time upper byte parks only", h, 8);
    wr(8'hA6, 8'h02);
    repeat (2) @(negedge clk);
    highs(16, h);
    check(h == 16, "R4 high-time commit 0x0102", h, 16);
    wr(8'hA7, 8'h00); wr(8'hA6, 8'h02);
    repeat (4) @(negedge clk);

    // R12 unmapped addresses
    wr(8'hA0, 8'h00); wr(8'hA8, 8'h00); wr(8'h00, 8'hFF); wr(8'hFF, 8'h00); wr(8'h24, 8'h00);
    repeat (2) @(negedge clk);
    highs(16, h);
    check(h == 8, "R12 unmapped writes ignored", h, 8);

    // R8 enable
    wr(8'hA3, 8'h00);
    repeat (2) @(negedge clk);
    highs(16, h);
    check(h == 0, "R8 enable 0 forces low", h, 0);
    wr(8'hA3, 8'h02);
    repeat (2) @(negedge clk);
    highs(16, h);
    check(h == 0, "R8 only bit 0 of enable counts", h, 0);
    wr(8'hA3, 8'h01);
    repeat (2) @(negedge clk);
    highs(16, h);
    check(h == 8, "R8 enable 1 restarts", h, 8);

    // R9 auto-off expiry: period 1 high 1 -> high every enabled cycle
    wr(8'hA3, 8'h00);
    set_wave(1, 1);
    wr(8'hA1, 8'h00); wr(8'hA2, 8'h03);
    repeat (2) @(negedge clk);
    begin
      int start;
      start = hi_total;
      wr(8'hA3, 8'h01);
      repeat (40) @(negedge clk);
      h = hi_total - start;
    end
    check(h >= 11 && h <= 15, "R9 expiry after 3 ms of 4 ticks", h, 13);
    highs(16, h);
    check(h == 0, "R9 output stays low after expiry", h, 0);
    wr(8'hA3, 8'h01);
    highs(16, h);
    check(h == 0, "R9 enable refused at zero timeout", h, 0);

    // R11 reload mid-countdown
    wr(8'hA2, 8'h02);
    repeat (2) @(negedge clk);
    begin
      int start;
      start = hi_total;
      wr(8'hA3, 8'h01);
      repeat (2) @(negedge clk);
      wr(8'hA2, 8'h06);
      repeat (60) @(negedge clk);
      h = hi_total - start;
    end
    check(h >= 27 && h <= 31, "R11 reload extends on-time", h, 29);

    // R10 idle timer
    wr(8'hA1, 8'hFF); wr(8'hA2, 8'hFF);
    repeat (2) @(negedge clk);
    wr(8'hA3, 8'h01);
    repeat (2) @(negedge clk);
    highs(200, h);
    check(h == 200, "R10 all-ones timeout never expires", h, 200);

    done = 1'b1;
    finish_run();
  end

endmodule